// File: doc/BRIEF.md
# Double-Edge Lane-to-Pixel Demultiplexer

This block sits behind a bank of differential line receivers that have already resolved each pair to a single logic level. It sees nine such data lanes and the shift clock that comes with them. Every lane carries two bits per clock period, one on each clock edge. The block pairs the two bits of each lane and places each pair at its fixed position in an 18-bit pixel word. The word holds three 6-bit colours: red, green and blue. A static polarity input can complement every received bit, which gives the same result as a link whose P and N wires are swapped.

The first bit of each lane is captured on the rising edge into a per-lane holding flop. It is joined with the second bit on the falling edge that follows. The assembled word and a one-cycle valid flag are registered on that falling edge. A completed pixel therefore appears once per clock period, in the falling-edge domain. The clock may run at up to 65 MHz. Deciding which of these words belong to a display line is left to a load controller further downstream.

Top module: `ddr_pixel_demux`

## Requirements
- R1: While `rst` is high at a falling edge, that edge drives `pix_word` to 0 and `pix_valid` to 0, whatever the lanes and `invert` carry. `rst` is also sampled on rising edges, where it clears the holding flops.
- R2: After `rst` is sampled low, `pix_valid` is 1 following every falling edge.
- R3: Lane number L = 3*c + k carries bits 2k and 2k+1 of colour c, where k is 0 to 2 and c is 0 for red, 1 for green and 2 for blue. The word places red in bits [5:0], green in bits [11:6] and blue in bits [17:12].
- R4: Within one clock period, the lane level at the rising edge supplies the lower bit of its pair and the level at the next falling edge supplies the upper bit. The word holding that pair is updated at that falling edge.
- R5: With `invert` at 1, every bit placed in the word is the complement of the lane level sampled. With `invert` at 0, bits pass unchanged.
- R6: Lane levels present only between the sampling edges have no effect on the word.
- R7: `pix_word` changes only at falling edges. A rising edge leaves it at the value set by the previous falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; both edges sample the lanes |
| rst | input | 1 | Synchronous active-high reset, sampled on both edges |
| lane_in | input | 9 | Resolved data lanes, lane L at bit L |
| invert | input | 1 | Static polarity select; 1 complements all bits |
| pix_word | output | 18 | Assembled pixel {blue, green, red} |
| pix_valid | output | 1 | High after each falling edge once out of reset |

## Verification
If a holding flop keeps a stale or wrongly inverted value, the wrong level shows in an even bit of `pix_word` right after the next falling edge. A lane that is mis-routed moves a single set bit to the wrong position in the word, so isolated one-lane patterns identify it within one pixel. A word register that is clocked on the wrong edge shows up as a change in `pix_word` half a period early, between the rising edge and the falling edge. A lost valid shows as `pix_valid` low after the first falling edge that follows release of reset.

// File: rtl/ddr_demux_pkg.sv
package ddr_demux_pkg;

  // Bits each lane carries per clock period (one per edge).
  localparam int BITS_PER_LANE = 2;

  // One lane's bit pair: early is sampled on the rising edge, late on the falling edge.
  typedef struct packed {
    logic late;
    logic early;
  } lane_pair_t;

endpackage

// File: rtl/ddr_lane_capture.sv
module ddr_lane_capture
  import ddr_demux_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       lane_in,
  input  logic       invert,
  output lane_pair_t pair
);

  logic bit_now;
  logic early_q;

  // Polarity is corrected before either edge uses the bit.
  assign bit_now = lane_in ^ invert;

  // Rising edge: hold the first bit of the pair.
  always_ff @(posedge clk) begin
    if (rst) begin
      early_q <= 1'b0;
    end else begin
      early_q <= bit_now;
    end
  end

  // The second bit is taken live; the word register samples it on the falling edge.
  assign pair.early = early_q;
  assign pair.late  = bit_now;

endmodule

// File: rtl/ddr_pixel_pack.sv
module ddr_pixel_pack #(
  parameter int LANES_PER_COLOUR = 3,
  parameter int NUM_COLOURS      = 3
) (
  input  logic [2*NUM_COLOURS*LANES_PER_COLOUR-1:0] pair_bus,
  output logic [2*NUM_COLOURS*LANES_PER_COLOUR-1:0] word_next
);

  localparam int COLOUR_W = 2 * LANES_PER_COLOUR;

  // Lane k of colour c fills bits 2k (early) and 2k+1 (late) of that colour.
  for (genvar c = 0; c < NUM_COLOURS; c++) begin : g_colour
    for (genvar k = 0; k < LANES_PER_COLOUR; k++) begin : g_lane
      localparam int LANE = c * LANES_PER_COLOUR + k;
      assign word_next[c*COLOUR_W + 2*k]     = pair_bus[2*LANE];
      assign word_next[c*COLOUR_W + 2*k + 1] = pair_bus[2*LANE + 1];
    end
  end

endmodule

// File: rtl/ddr_word_reg.sv
module ddr_word_reg #(
  parameter int WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_next,
  output logic [WORD_W-1:0] pix_word,
  output logic              pix_valid
);

  // Falling-edge commit of the completed pixel.
  always_ff @(negedge clk) begin
    if (rst) begin
      pix_word  <= '0;
      pix_valid <= 1'b0;
    end else begin
      pix_word  <= word_next;
      pix_valid <= 1'b1;
    end
  end

endmodule

// File: rtl/ddr_pixel_demux.sv
module ddr_pixel_demux
  import ddr_demux_pkg::*;
#(
  parameter int LANES_PER_COLOUR = 3,
  parameter int NUM_COLOURS      = 3
) (
  input  logic                                             clk,
  input  logic                                             rst,
  input  logic [NUM_COLOURS*LANES_PER_COLOUR-1:0]          lane_in,
  input  logic                                             invert,
  output logic [BITS_PER_LANE*NUM_COLOURS*LANES_PER_COLOUR-1:0] pix_word,
  output logic                                             pix_valid
);

  localparam int NUM_LANES = NUM_COLOURS * LANES_PER_COLOUR;
  localparam int WORD_W    = BITS_PER_LANE * NUM_LANES;

  logic [WORD_W-1:0] pair_bus;
  logic [WORD_W-1:0] word_next;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_cap
    lane_pair_t pair;
    ddr_lane_capture u_cap (
      .clk     (clk),
      .rst     (rst),
      .lane_in (lane_in[l]),
      .invert  (invert),
      .pair    (pair)
    );
    assign pair_bus[BITS_PER_LANE*l +: BITS_PER_LANE] = pair;
  end

  ddr_pixel_pack #(
    .LANES_PER_COLOUR (LANES_PER_COLOUR),
    .NUM_COLOURS      (NUM_COLOURS)
  ) u_pack (
    .pair_bus  (pair_bus),
    .word_next (word_next)
  );

  ddr_word_reg #(
    .WORD_W (WORD_W)
  ) u_wreg (
    .clk       (clk),
    .rst       (rst),
    .word_next (word_next),
    .pix_word  (pix_word),
    .pix_valid (pix_valid)
  );

endmodule

// File: rtl/ddr_pixel_demux_chk.sv
module ddr_pixel_demux_chk #(
  parameter int LANES_PER_COLOUR = 3,
  parameter int NUM_COLOURS      = 3
) (
  input logic                                       clk,
  input logic                                       rst,
  input logic [NUM_COLOURS*LANES_PER_COLOUR-1:0]    lane_in,
  input logic                                       invert,
  input logic [2*NUM_COLOURS*LANES_PER_COLOUR-1:0]  pix_word,
  input logic                                       pix_valid
);

  localparam int NUM_LANES = NUM_COLOURS * LANES_PER_COLOUR;
  localparam int COLOUR_W  = 2 * LANES_PER_COLOUR;

  logic [NUM_LANES-1:0]   odd_of_word;
  logic [NUM_LANES-1:0]   even_of_word;
  logic [NUM_LANES-1:0]   rise_seen;
  logic [2*NUM_LANES-1:0] word_at_rise;

  // Regroup the output word back into per-lane bit streams.
  always_comb begin
    for (int c = 0; c < NUM_COLOURS; c++) begin
      for (int k = 0; k < LANES_PER_COLOUR; k++) begin
        even_of_word[c*LANES_PER_COLOUR + k] = pix_word[c*COLOUR_W + 2*k];
        odd_of_word[c*LANES_PER_COLOUR + k]  = pix_word[c*COLOUR_W + 2*k + 1];
      end
    end
  end

  // Port-level record of what was on the lanes at each rising edge, and the word seen there.
  always_ff @(posedge clk) begin
    if (rst) begin
      rise_seen <= '0;
    end else begin
      rise_seen <= lane_in ^ {NUM_LANES{invert}};
    end
    word_at_rise <= pix_word;
  end

  AST_VALID_EVERY_FALL: assert property (@(negedge clk) disable iff (rst)
    !$past(rst) |-> pix_valid); // R2

  AST_ODD_BITS_MATCH: assert property (@(negedge clk) disable iff (rst)
    !$past(rst) |-> odd_of_word == $past(lane_in ^ {NUM_LANES{invert}})); // R3

  AST_EVEN_BITS_MATCH: assert property (@(negedge clk) disable iff (rst)
    !$past(rst) |-> even_of_word == $past(rise_seen)); // R4

  AST_WORD_FALL_ONLY: assert property (@(negedge clk) disable iff (rst)
    !$past(rst) |-> pix_word == word_at_rise); // R7

endmodule

bind ddr_pixel_demux ddr_pixel_demux_chk #(
  .LANES_PER_COLOUR (LANES_PER_COLOUR),
  .NUM_COLOURS      (NUM_COLOURS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lane_in   (lane_in),
  .invert    (invert),
  .pix_word  (pix_word),
  .pix_valid (pix_valid)
);

// File: tb/ddr_pixel_demux_tb.sv
`timescale 1ns/100ps
module ddr_pixel_demux_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [8:0]  lane_in = '0;
  logic        invert = 1'b0;
  logic [17:0] pix_word;
  logic        pix_valid;

  int n_chk  = 0;
  int n_fail = 0;
  logic [17:0] word_mid;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  ddr_pixel_demux u_dut (
    .clk       (clk),
    .rst       (rst),
    .lane_in   (lane_in),
    .invert    (invert),
    .pix_word  (pix_word),
    .pix_valid (pix_valid)
  );

  // {invert, intended pixel word}
  localparam logic [18:0] VECS [10] = '{
    {1'b0, 18'h00000}, {1'b0, 18'h3FFFF}, {1'b0, 18'h15555}, {1'b0, 18'h2AAAA},
    {1'b0, 18'h0003F}, {1'b0, 18'h00FC0}, {1'b0, 18'h3F000}, {1'b1, 18'h12345},
    {1'b1, 18'h00000}, {1'b1, 18'h2C3A5}
  };

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Per R3: lane 3c+k carries bit 2k (rising) and 2k+1 (falling) of colour c.
  function automatic logic [8:0] lanes_of(input logic [17:0] w, input int odd);
    logic [8:0] l;
    for (int c = 0; c < 3; c++)
      for (int k = 0; k < 3; k++)
        l[3*c + k] = w[6*c + 2*k + odd];
    return l;
  endfunction

  // Starts 1 ns after a falling edge, ends 1 ns after the next falling edge.
  task automatic pixel_raw(input logic [8:0] ev, input logic [8:0] od,
                           input logic inv, input logic glitch);
    invert  = inv;
    lane_in = ev;
    @(posedge clk);
    #0.5;
    word_mid = pix_word;
    if (glitch) lane_in = ~od;
    #1;
    lane_in = od;
    @(negedge clk);
    #0.5;
    if (glitch) lane_in = ~ev;
    #0.5;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    lane_in = 9'h1FF;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 word in reset", pix_word, 18'h0);
    chk("R1 valid in reset", {17'b0, pix_valid}, 18'h0);
    rst = 1'b0;

    // Table walk: lanes carry the intended word, pre-inverted when invert is set.
    foreach (VECS[i]) begin
      logic        inv;
      logic [17:0] w;
      logic [17:0] prev;
      inv  = VECS[i][18];
      w    = VECS[i][17:0];
      prev = pix_word;
      pixel_raw(lanes_of(w, 0) ^ {9{inv}}, lanes_of(w, 1) ^ {9{inv}}, inv, 1'b0);
      chk("R3 R4 R5 table word", pix_word, w);
      chk("R2 valid each fall", {17'b0, pix_valid}, 18'h1);
      chk("R7 word held at rise", word_mid, prev);
    end

    // R3: isolated lanes land on their own bit.
    pixel_raw(9'b000010000, 9'b000000000, 1'b0, 1'b0);
    chk("R3 lane4 rising to bit8", pix_word, 18'h00100);
    pixel_raw(9'b000000000, 9'b100000000, 1'b0, 1'b0);
    chk("R3 lane8 falling to bit17", pix_word, 18'h20000);
    pixel_raw(9'b000000001, 9'b000000000, 1'b0, 1'b0);
    chk("R4 lane0 rising is bit0", pix_word, 18'h00001);

    // R5: raw lane levels with and without inversion.
    pixel_raw(9'h000, 9'h000, 1'b1, 1'b0);
    chk("R5 invert all-zero lanes", pix_word, 18'h3FFFF);
    pixel_raw(9'h1FF, 9'h1FF, 1'b1, 1'b0);
    chk("R5 invert all-one lanes", pix_word, 18'h00000);
    pixel_raw(9'h1FF, 9'h000, 1'b0, 1'b0);
    chk("R5 no invert even bits", pix_word, 18'h15555);

    // R6: opposite levels between sampling edges are ignored.
    pixel_raw(lanes_of(18'h0F0F0, 0), lanes_of(18'h0F0F0, 1), 1'b0, 1'b1);
    chk("R6 glitches ignored", pix_word, 18'h0F0F0);
    pixel_raw(lanes_of(18'h3C3C3, 0), lanes_of(18'h3C3C3, 1), 1'b0, 1'b1);
    chk("R6 glitches ignored again", pix_word, 18'h3C3C3);

    // R1 mid-run, then R2 after release.
    rst = 1'b1;
    lane_in = 9'h1FF;
    @(posedge clk);
    @(negedge clk);
    #1;
    chk("R1 word cleared mid-run", pix_word, 18'h0);
    chk("R1 valid cleared mid-run", {17'b0, pix_valid}, 18'h0);
    rst = 1'b0;
    pixel_raw(lanes_of(18'h2A5A5, 0), lanes_of(18'h2A5A5, 1), 1'b0, 1'b0);
    chk("R2 valid after release", {17'b0, pix_valid}, 18'h1);
    chk("R4 word after release", pix_word, 18'h2A5A5);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule